// File: doc/BRIEF.md
# Burst-Mode Controller Engine

This block is a clocked, table-driven emulation of a burst-mode state machine. It watches a small input vector. It stays in its current state, holding its outputs, until one of that state's outgoing arcs has seen all of its input edges. Those edges may arrive in any order and with any number of cycles between them. When the last edge of such a burst lands, the engine applies the arc's output burst and enters the arc's next state.

Progress toward a burst is measured against the input values latched when the state was entered. It is not measured against the inputs present on any single clock. The transition table is set through parameter arrays with one entry per arc. Each entry holds:
- the source state,
- the input mask and the target input values,
- the output mask and the output values,
- the next state.

A sticky flag reports any input activity that the table does not allow.

The default table has five states (codes 0 to 4) and three inputs and outputs. Inputs a, b and c are `in_i[0]`, `in_i[1]` and `in_i[2]`. Each arc below is written as source, then the input burst, then `->` the destination, followed by the resulting outputs.
- S0: a+ -> S1, setting out to 001.
- S0: b+ and c+ -> S2, setting `out_o[1]`.
- S1: a- -> S0, clearing `out_o[0]`.
- S2: b- and c- -> S3, clearing `out_o[1]` and setting `out_o[2]`.
- S3: c+ -> S4, with an empty output burst.
- S4: a+ and c- -> S1, clearing `out_o[2]` and setting `out_o[0]`.

Top module: `bm_engine`

## Requirements
- R1: After reset, `state_o` is the start code 0, `out_o` is 000, `viol_o` is 0, and the entry input values are 000.
- R2: With no input change, the state and outputs never change. An arc fires only if at least one masked input differs from the entry value.
- R3: When only part of a burst has arrived, the state and outputs hold, for any number of cycles.
- R4: A burst completes when every masked input equals its target, whatever the order and spacing of the edges. The engine then moves to the arc's next state. Examples are b+ then c+ from S0 to S2, c+ then b+ likewise, and c- then a+ from S4 to S1.
- R5: On a transition, only the output bits in the arc's output mask change, and each takes the arc's output value. The S2 to S3 arc turns out 010 into 100.
- R6: An arc with an empty output burst changes the state and leaves every output bit as it was. S3 on c+ goes to S4 with out staying 100.
- R7: State and outputs change together on the third rising clock edge after an input is applied: two synchronizer stages, then the state register. After two edges nothing has changed.
- R8: On a transition, the new state's entry input values are taken from the synchronized inputs on the same edge. In S2, entered with b and c high, falling b and c completes the next burst.
- R9: An input that differs from its entry value in a direction that no arc of the current state accepts sets `viol_o`. An example is b+ in S1.
- R10: An input that changes and then returns to its entry value within one state sets `viol_o`. An example is b+ then b- in S0.
- R11: `viol_o` is sticky and only reset clears it. Transitions keep working while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_i | input | N_IN | Raw input vector, synchronized internally |
| out_o | output | N_OUT | Current output vector |
| state_o | output | ST_W | Current state code |
| viol_o | output | 1 | Sticky protocol-violation flag |

## Verification
The bench drives bursts in both edge orders, with long gaps, and with edges arriving together. An engine that looked at the current input value rather than the set of edges since entry would fire early on a partial burst, or never fire on the reverse order. The bench also checks the exact edge on which state and outputs move. It checks an arc with an empty output burst and an arc whose mask leaves a bit untouched, which catches output updates that ignore the mask. A revert and a wrong-direction edge are checked for the sticky flag, and the flag is checked to survive a later transition and clear only on reset.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int unsigned MAX_ST  = 8;
  localparam int unsigned MAX_IO  = 8;
endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/bm_arc_match.sv
module bm_arc_match #(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned N_OUT = 3,
  parameter int unsigned ST_W  = 3,
  parameter int unsigned N_ARC = 6,
  parameter logic [N_ARC-1:0][ST_W-1:0]  ARC_SRC   = '0,
  parameter logic [N_ARC-1:0][N_IN-1:0]  ARC_IMASK = '0,
  parameter logic [N_ARC-1:0][N_IN-1:0]  ARC_ITGT  = '0,
  parameter logic [N_ARC-1:0][N_OUT-1:0] ARC_OMASK = '0,
  parameter logic [N_ARC-1:0][N_OUT-1:0] ARC_OVAL  = '0,
  parameter logic [N_ARC-1:0][ST_W-1:0]  ARC_NEXT  = '0
) (
  input  logic [ST_W-1:0]  state_i,
  input  logic [N_IN-1:0]  entry_i,
  input  logic [N_IN-1:0]  in_i,
  output logic             fire_o,
  output logic [ST_W-1:0]  next_o,
  output logic [N_OUT-1:0] omask_o,
  output logic [N_OUT-1:0] oval_o,
  output logic [N_IN-1:0]  legal_o
);
  logic [N_ARC-1:0] hit;

  for (genvar a = 0; a < N_ARC; a++) begin : g_arc
    // complete: all masked bits at target, and at least one edge taken
    assign hit[a] = (ARC_SRC[a] == state_i)
                 && (((in_i ^ ARC_ITGT[a]) & ARC_IMASK[a]) == '0)
                 && (((in_i ^ entry_i) & ARC_IMASK[a]) != '0);
  end

  // bits whose present value some arc of this state accepts
  always_comb begin
    legal_o = '0;
    for (int a = 0; a < N_ARC; a++) begin
      if (ARC_SRC[a] == state_i)
        legal_o = legal_o | (ARC_IMASK[a] & ~(in_i ^ ARC_ITGT[a]));
    end
  end

  // lowest arc index wins if two complete on one sample
  always_comb begin
    fire_o  = |hit;
    next_o  = '0;
    omask_o = '0;
    oval_o  = '0;
    for (int a = N_ARC - 1; a >= 0; a--) begin
      if (hit[a]) begin
        next_o  = ARC_NEXT[a];
        omask_o = ARC_OMASK[a];
        oval_o  = ARC_OVAL[a];
      end
    end
  end
endmodule

// File: rtl/bm_engine.sv
module bm_engine import bm_pkg::*; #(
  parameter int unsigned N_IN  = 3,
  parameter int unsigned N_OUT = 3,
  parameter int unsigned N_ST  = 5,
  parameter int unsigned ST_W  = 3,
  parameter int unsigned N_ARC = 6,
  parameter logic [ST_W-1:0]  START    = '0,
  parameter logic [N_IN-1:0]  INIT_IN  = '0,
  parameter logic [N_OUT-1:0] INIT_OUT = '0,
  parameter logic [N_ARC-1:0][ST_W-1:0]  ARC_SRC   = {3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd0},
  parameter logic [N_ARC-1:0][N_IN-1:0]  ARC_IMASK = {3'b101, 3'b100, 3'b110, 3'b001, 3'b110, 3'b001},
  parameter logic [N_ARC-1:0][N_IN-1:0]  ARC_ITGT  = {3'b001, 3'b100, 3'b000, 3'b000, 3'b110, 3'b001},
  parameter logic [N_ARC-1:0][N_OUT-1:0] ARC_OMASK = {3'b101, 3'b000, 3'b110, 3'b001, 3'b010, 3'b001},
  parameter logic [N_ARC-1:0][N_OUT-1:0] ARC_OVAL  = {3'b001, 3'b000, 3'b100, 3'b000, 3'b010, 3'b001},
  parameter logic [N_ARC-1:0][ST_W-1:0]  ARC_NEXT  = {3'd1, 3'd4, 3'd3, 3'd0, 3'd2, 3'd1}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  in_i,
  output logic [N_OUT-1:0] out_o,
  output logic [ST_W-1:0]  state_o,
  output logic             viol_o
);
  if (N_ST > MAX_ST || N_IN > MAX_IO || N_OUT > MAX_IO || (1 << ST_W) < N_ST) begin : g_bad_cfg
    $error("bm_engine: table size out of range");
  end

  logic [N_IN-1:0]  sync_in;
  logic [ST_W-1:0]  state_q;
  logic [N_OUT-1:0] out_q;
  logic [N_IN-1:0]  entry_q, seen_q, changed, legal;
  logic             viol_q, bad;
  logic             fire;
  logic [ST_W-1:0]  sel_next;
  logic [N_OUT-1:0] sel_om, sel_ov;

  bm_sync #(.W(N_IN), .RST_VAL(INIT_IN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (in_i),
    .q_o   (sync_in)
  );

  bm_arc_match #(
    .N_IN(N_IN), .N_OUT(N_OUT), .ST_W(ST_W), .N_ARC(N_ARC),
    .ARC_SRC(ARC_SRC), .ARC_IMASK(ARC_IMASK), .ARC_ITGT(ARC_ITGT),
    .ARC_OMASK(ARC_OMASK), .ARC_OVAL(ARC_OVAL), .ARC_NEXT(ARC_NEXT)
  ) u_match (
    .state_i(state_q),
    .entry_i(entry_q),
    .in_i   (sync_in),
    .fire_o (fire),
    .next_o (sel_next),
    .omask_o(sel_om),
    .oval_o (sel_ov),
    .legal_o(legal)
  );

  assign changed = sync_in ^ entry_q;
  // wrong-direction edge, or a bit that moved and came back
  assign bad = (|(changed & ~legal)) | (|(seen_q & ~changed));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= START;
      out_q   <= INIT_OUT;
      entry_q <= INIT_IN;
      seen_q  <= '0;
      viol_q  <= 1'b0;
    end else begin
      viol_q <= viol_q | bad;
      if (fire) begin
        state_q <= sel_next;
        out_q   <= (out_q & ~sel_om) | (sel_ov & sel_om);
        entry_q <= sync_in;
        seen_q  <= '0;
      end else begin
        seen_q  <= seen_q | changed;
      end
    end
  end

  assign out_o   = out_q;
  assign state_o = state_q;
  assign viol_o  = viol_q;

  p_nonempty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> (sync_in != entry_q));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> ($stable(state_o) && $stable(out_o)));

  p_next_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (state_o == $past(sel_next)));

  p_out_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (((out_o ^ $past(out_o)) & ~$past(sel_om)) == '0));

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> viol_o);
endmodule

// File: tb/tb_bm_engine.sv
module tb_bm_engine;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] in_i = 3'b000;
  logic [2:0] out_o;
  logic [2:0] state_o;
  logic       viol_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [2:0] st;
    logic [2:0] out;
    logic       v;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk_i = ~clk_i;

  bm_engine dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (in_i),
    .out_o  (out_o),
    .state_o(state_o),
    .viol_o (viol_o)
  );

  task automatic compare(input exp_t e);
    n_tests++;
    if (state_o !== e.st || out_o !== e.out || viol_o !== e.v) begin
      n_fail++;
      $display("FAIL %s: got st=%0d out=%b viol=%b, exp st=%0d out=%b viol=%b",
               e.tag, state_o, out_o, viol_o, e.st, e.out, e.v);
    end
  endtask

  task automatic push(input logic [2:0] st, input logic [2:0] o, input logic v, input string tag);
    exp_t e;
    e.st = st; e.out = o; e.v = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // drive one input vector, let it settle, queue the expected result
  task automatic apply(input logic [2:0] v, input logic [2:0] st, input logic [2:0] o,
                       input logic vi, input string tag);
    @(negedge clk_i);
    in_i = v;
    repeat (4) @(negedge clk_i);
    push(st, o, vi, tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk_i);
    in_i   = 3'b000;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    push(3'd0, 3'b000, 1'b0, tag);
  endtask

  // monitor: pops and compares shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      #1;
      while (sb_q.size() > 0) compare(sb_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t e;
    do_reset("R1 reset state");
    apply(3'b000, 3'd0, 3'b000, 1'b0, "R2 idle stays");
    repeat (20) @(negedge clk_i);
    push(3'd0, 3'b000, 1'b0, "R2 long idle");

    // b then c with a long gap
    apply(3'b010, 3'd0, 3'b000, 1'b0, "R3 partial b+");
    repeat (30) @(negedge clk_i);
    push(3'd0, 3'b000, 1'b0, "R3 partial held");
    apply(3'b110, 3'd2, 3'b010, 1'b0, "R4 b+ then c+");
    // S2 entered with 110; falling edges measured from there
    apply(3'b100, 3'd2, 3'b010, 1'b0, "R8 partial b-");
    apply(3'b000, 3'd3, 3'b100, 1'b0, "R5 R8 masked outputs");
    apply(3'b100, 3'd4, 3'b100, 1'b0, "R6 empty output burst");
    apply(3'b000, 3'd4, 3'b100, 1'b0, "R3 partial c-");
    apply(3'b001, 3'd1, 3'b001, 1'b0, "R4 c- then a+");
    apply(3'b000, 3'd0, 3'b000, 1'b0, "R4 a- back to S0");

    // reverse order and simultaneous edges
    apply(3'b100, 3'd0, 3'b000, 1'b0, "R3 partial c+");
    apply(3'b110, 3'd2, 3'b010, 1'b0, "R4 c+ then b+");
    apply(3'b000, 3'd3, 3'b100, 1'b0, "R4 b- c- together");
    apply(3'b100, 3'd4, 3'b100, 1'b0, "R6 c+ S3");
    apply(3'b001, 3'd1, 3'b001, 1'b0, "R4 a+ c- together");
    apply(3'b000, 3'd0, 3'b000, 1'b0, "R4 return S0");

    // exact edge of update
    @(negedge clk_i);
    in_i = 3'b001;
    repeat (2) @(negedge clk_i);
    e.st = 3'd0; e.out = 3'b000; e.v = 1'b0; e.tag = "R7 unchanged after two edges";
    sb_q.push_back(e);
    @(negedge clk_i);
    e.st = 3'd1; e.out = 3'b001; e.v = 1'b0; e.tag = "R7 updated on third edge";
    sb_q.push_back(e);
    repeat (2) @(negedge clk_i);

    // wrong-direction edge in S1, then sticky across a transition
    apply(3'b011, 3'd1, 3'b001, 1'b1, "R9 b+ illegal in S1");
    apply(3'b001, 3'd1, 3'b001, 1'b1, "R11 flag held");
    apply(3'b000, 3'd0, 3'b000, 1'b1, "R11 transition with flag set");
    do_reset("R11 reset clears flag");

    // revert within a state
    apply(3'b010, 3'd0, 3'b000, 1'b0, "R10 b+ legal so far");
    apply(3'b000, 3'd0, 3'b000, 1'b1, "R10 b reverted");
    do_reset("R1 reset after revert");

    // illegal a+ in S2
    apply(3'b110, 3'd2, 3'b010, 1'b0, "R4 to S2 together");
    apply(3'b111, 3'd2, 3'b010, 1'b1, "R9 a+ illegal in S2");

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule